// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sits between a processor register bus and a successive-approximation converter. It controls when conversions run and which channel each one uses. An 8-bit control register holds four things: the channel select, a one-shot start bit that clears itself, a continuous-run enable, and a memory-driven sequence enable. Register bit 7 is an interrupt flag. The block drives the converter with a one-cycle start pulse and a 4-bit channel code. It then waits for the converter's one-cycle done pulse.

In memory-sequence mode the block reads channel codes from a small memory port, starting at address 0. It converts each valid code in turn and stops when it reads the stop code. At the end it clears its own enable bit and raises the interrupt flag. The flag can be cleared in two ways: by an interrupt-vector acknowledge pulse, or by software writing 0 to bit 7.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `irq_o` is 0, and neither `conv_start_o` nor `mem_rd_o` is asserted.
- R2: The register fields are: bit 7 interrupt flag, bit 6 sequence enable, bit 5 continuous enable, bit 4 single start, bits 3..0 channel select. A write loads bits 7, 6, 5 and 3..0 as written. A read returns the current state. `irq_o` equals bit 7.
- R3: Writing 1 to bit 4 with a valid select (0..12) and bit 6 at 0 causes a conversion. `conv_start_o` is high in the second cycle after the write cycle, with `conv_chan_o` equal to the select. Bit 4 reads 1 until the conversion finishes, then 0.
- R4: The flag is set in two cases: in the cycle after `conv_done_i` ends any conversion outside sequence mode, and in the cycle after the stop code ends a sequence.
- R5: An `irq_ack_i` pulse clears the flag. A write with bit 7 at 0 also clears it. A hardware set in the same cycle wins over both.
- R6: While bit 5 is 1 and the select is valid, a new conversion starts by itself. Its `conv_start_o` is high in the second cycle after the cycle in which `conv_done_i` was high. Once bit 5 is cleared, no further start follows.
- R7: While a conversion is in flight, a write with bit 4 set starts no second conversion and leaves bit 4 unchanged. The other fields still update.
- R8: A select of 13, 14 or 15 never causes a start or a flag, in either single or continuous mode. After such a single-start write, bit 4 reads 0.
- R9: Setting bit 6 starts a sequence. The block pulses `mem_rd_o` for one cycle per read, at addresses 0, 1, 2 and so on, and samples `mem_data_i` in the following cycle. Codes 0..12 are converted on that code, ignoring the select. Codes 13 and 14 are skipped. Code 15 ends the sequence and clears bit 6, and the next sequence starts again at address 0.
- R10: When bits 6 and 5 are both set, the sequence runs first and no continuous conversion starts until it ends. Continuous conversions then resume on the select.
- R11: `conv_start_o` is a single-cycle pulse. No new start is issued before the converter answers the previous one. `conv_chan_o` is held steady while a conversion is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| irq_ack_i | input | 1 | Interrupt vector acknowledge pulse |
| irq_o | output | 1 | Interrupt flag |
| conv_start_o | output | 1 | One-cycle conversion request |
| conv_chan_o | output | 4 | Channel code for the conversion |
| conv_done_i | input | 1 | One-cycle conversion-complete pulse |
| mem_rd_o | output | 1 | Sequence memory read strobe |
| mem_addr_o | output | ADDR_W | Sequence memory address |
| mem_data_i | input | 4 | Channel code read from memory, valid the cycle after a read |

## Verification
Some rules are checked by assertions on every cycle: the start pulse lasts one cycle and only one conversion is outstanding; a started channel is never reserved; the channel is held steady; a memory code is converted on the next cycle; sequence mode blocks register-driven starts; and the register bits take their hardware set and clear values one cycle after the event. Other behaviour shows only in the bench's scenarios. These are the sweep of all sixteen select codes in single mode, the restart spacing in continuous mode, ignored re-starts during a conversion, complete memory sequences including skipped codes and an empty list, and the hand-over from a sequence back to continuous mode.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CHAN_W = 4;
  localparam logic [CHAN_W-1:0] CH_MAX_OK = 4'd12;
  localparam logic [CHAN_W-1:0] CH_STOP   = 4'd15;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DATA, ST_CONV} seq_state_e;

  // packed MSB first: flag is bit 7, chan is bits 3..0
  typedef struct packed {
    logic              flag;
    logic              dma;
    logic              cont;
    logic              single;
    logic [CHAN_W-1:0] chan;
  } ctrl_t;

  localparam int REG_W = $bits(ctrl_t);

  function automatic logic chan_ok(input logic [CHAN_W-1:0] c);
    return c <= CH_MAX_OK;
  endfunction
endpackage

// File: rtl/adc_seq_reg.sv
module adc_seq_reg
  import adc_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  ctrl_t wdata_i,
  input  logic  busy_i,
  input  logic  irq_ack_i,
  input  logic  flag_set_i,
  input  logic  single_clr_i,
  input  logic  dma_clr_i,
  output ctrl_t ctrl_o
);
  ctrl_t ctrl_q;
  logic  single_ok;

  // single start accepted only when idle, not in sequence mode, on a legal channel
  assign single_ok = wdata_i.single && !wdata_i.dma && chan_ok(wdata_i.chan);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_i) begin
        ctrl_q.flag <= wdata_i.flag;
        ctrl_q.dma  <= wdata_i.dma;
        ctrl_q.cont <= wdata_i.cont;
        ctrl_q.chan <= wdata_i.chan;
        if (!busy_i) ctrl_q.single <= single_ok;
      end
      // later assignments take priority: hardware over software
      if (irq_ack_i)    ctrl_q.flag   <= 1'b0;
      if (flag_set_i)   ctrl_q.flag   <= 1'b1;
      if (single_clr_i) ctrl_q.single <= 1'b0;
      if (dma_clr_i)    ctrl_q.dma    <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;

  p_flag_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_set_i |=> ctrl_q.flag);
  p_ack_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !flag_set_i) |=> !ctrl_q.flag);
  p_single_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_clr_i |=> !ctrl_q.single);
  p_dma_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_clr_i |=> !ctrl_q.dma);
  p_busy_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_i && !single_clr_i) |=> (ctrl_q.single == $past(ctrl_q.single)));
endmodule

// File: rtl/adc_seq_ptr.sv
module adc_seq_ptr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (clr_i) addr_q <= '0;
    else if (inc_i) addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_en_i,
  input  logic              cont_en_i,
  input  logic              single_en_i,
  input  logic [CHAN_W-1:0] sel_chan_i,
  input  logic              conv_done_i,
  input  logic [CHAN_W-1:0] mem_data_i,
  output logic              conv_start_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  output logic              mem_rd_o,
  output logic              ptr_inc_o,
  output logic              ptr_clr_o,
  output logic              busy_o,
  output logic              flag_set_o,
  output logic              single_clr_o,
  output logic              dma_clr_o
);
  seq_state_e        state_q, state_d;
  logic              start_q, start_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic              cur_dma_q, cur_dma_d;
  logic              cur_single_q, cur_single_d;

  always_comb begin
    state_d      = state_q;
    start_d      = 1'b0;
    chan_d       = chan_q;
    cur_dma_d    = cur_dma_q;
    cur_single_d = cur_single_q;
    ptr_inc_o    = 1'b0;
    ptr_clr_o    = 1'b0;
    flag_set_o   = 1'b0;
    single_clr_o = 1'b0;
    dma_clr_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (dma_en_i) begin
          state_d      = ST_FETCH;
          cur_dma_d    = 1'b1;
          cur_single_d = 1'b0;
        end else if ((single_en_i || cont_en_i) && chan_ok(sel_chan_i)) begin
          state_d      = ST_CONV;
          start_d      = 1'b1;
          chan_d       = sel_chan_i;
          cur_dma_d    = 1'b0;
          cur_single_d = single_en_i;
        end
      end
      ST_FETCH: state_d = ST_DATA;
      ST_DATA: begin
        if (mem_data_i == CH_STOP) begin
          state_d    = ST_IDLE;
          cur_dma_d  = 1'b0;
          ptr_clr_o  = 1'b1;
          dma_clr_o  = 1'b1;
          flag_set_o = 1'b1;
        end else if (chan_ok(mem_data_i)) begin
          state_d   = ST_CONV;
          start_d   = 1'b1;
          chan_d    = mem_data_i;
          ptr_inc_o = 1'b1;
        end else begin
          // reserved code inside a sequence: skip it
          state_d   = ST_FETCH;
          ptr_inc_o = 1'b1;
        end
      end
      ST_CONV: begin
        if (conv_done_i) begin
          if (cur_dma_q) begin
            state_d = ST_FETCH;
          end else begin
            state_d      = ST_IDLE;
            flag_set_o   = 1'b1;
            single_clr_o = cur_single_q;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      start_q      <= 1'b0;
      chan_q       <= '0;
      cur_dma_q    <= 1'b0;
      cur_single_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      start_q      <= start_d;
      chan_q       <= chan_d;
      cur_dma_q    <= cur_dma_d;
      cur_single_q <= cur_single_d;
    end
  end

  assign conv_start_o = start_q;
  assign conv_chan_o  = chan_q;
  assign mem_rd_o     = (state_q == ST_FETCH);
  assign busy_o       = (state_q != ST_IDLE);

  p_start_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  p_one_inflight_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && !conv_done_i) |=> !conv_start_o);
  p_chan_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && !conv_start_o) |-> $stable(conv_chan_o));
  p_no_reserved_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> chan_ok(conv_chan_o));
  p_mem_chan_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && chan_ok(mem_data_i))
      |=> (conv_start_o && conv_chan_o == $past(mem_data_i)));
  p_rd_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
  p_dma_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && dma_en_i) |=> (!conv_start_o && mem_rd_o));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              irq_ack_i,
  output logic              irq_o,
  output logic              conv_start_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  input  logic              conv_done_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [CHAN_W-1:0] mem_data_i
);
  ctrl_t ctrl, wdata;
  logic  busy, flag_set, single_clr, dma_clr, ptr_inc, ptr_clr;

  assign wdata = ctrl_t'(reg_wdata_i);

  adc_seq_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .wdata_i     (wdata),
    .busy_i      (busy),
    .irq_ack_i   (irq_ack_i),
    .flag_set_i  (flag_set),
    .single_clr_i(single_clr),
    .dma_clr_i   (dma_clr),
    .ctrl_o      (ctrl)
  );

  adc_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dma_en_i    (ctrl.dma),
    .cont_en_i   (ctrl.cont),
    .single_en_i (ctrl.single),
    .sel_chan_i  (ctrl.chan),
    .conv_done_i (conv_done_i),
    .mem_data_i  (mem_data_i),
    .conv_start_o(conv_start_o),
    .conv_chan_o (conv_chan_o),
    .mem_rd_o    (mem_rd_o),
    .ptr_inc_o   (ptr_inc),
    .ptr_clr_o   (ptr_clr),
    .busy_o      (busy),
    .flag_set_o  (flag_set),
    .single_clr_o(single_clr),
    .dma_clr_o   (dma_clr)
  );

  adc_seq_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ptr_clr),
    .inc_i (ptr_inc),
    .addr_o(mem_addr_o)
  );

  assign reg_rdata_o = REG_W'(ctrl);
  assign irq_o       = ctrl.flag;

  p_irq_mirror_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == reg_rdata_o[REG_W-1]);
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int ADDR_W     = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [7:0]        reg_wdata = '0;
  logic [7:0]        reg_rdata;
  logic              irq_ack = 1'b0;
  logic              irq;
  logic              conv_start;
  logic [3:0]        conv_chan;
  logic              conv_done = 1'b0;
  logic              mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [3:0]        mem_data = '0;

  adc_seq_ctrl #(.ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_ack_i(irq_ack), .irq_o(irq),
    .conv_start_o(conv_start), .conv_chan_o(conv_chan), .conv_done_i(conv_done),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done_flag = 0;
  int cyc = 0, cnt = 0, n_start = 0, n_rd = 0, overlap = 0;
  int log_ch [0:255];
  int log_t  [0:255];
  logic [3:0] mem [0:(1<<ADDR_W)-1];

  // converter and memory models
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      cnt <= 0; conv_done <= 1'b0;
    end else begin
      conv_done <= 1'b0;
      if (cnt != 0) begin
        if (cnt == 1) conv_done <= 1'b1;
        cnt <= cnt - 1;
      end
      if (conv_start) begin
        if (cnt != 0 || conv_done) overlap <= overlap + 1;
        cnt <= LAT;
        log_ch[n_start % 256] <= int'(conv_chan);
        log_t[n_start % 256]  <= cyc;
        n_start <= n_start + 1;
      end
      if (mem_rd) begin
        mem_data <= mem[mem_addr];
        n_rd <= n_rd + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int max);
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int base, rbase, n1;
    for (int i = 0; i < (1<<ADDR_W); i++) mem[i] = 4'd15;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(reg_rdata == 8'h00, "R1 reset reg", reg_rdata, 0);
    chk(!irq && !conv_start && !mem_rd, "R1 reset outputs", {irq, conv_start, mem_rd}, 0);

    // R2 plain write/readback, no start
    base = n_start;
    wr(8'h0A); idle(10);
    chk(reg_rdata == 8'h0A, "R2 readback", reg_rdata, 8'h0A);
    chk(n_start == base, "R2 no start", n_start - base, 0);

    // R8 continuous on reserved select
    wr(8'h2D); idle(15);
    chk(n_start == base, "R8 cont reserved no start", n_start - base, 0);
    chk(reg_rdata == 8'h2D && !irq, "R8 cont reserved reg", reg_rdata, 8'h2D);
    wr(8'h00);

    // R3/R4/R5/R8 single-start sweep over all select codes
    for (int c = 0; c < 16; c++) begin
      bit ok;
      ok = (c <= 12);
      base = n_start;
      wr(8'h10 | 8'(c));
      @(negedge clk);
      chk(conv_start == ok, "R3 start timing", conv_start, ok);
      if (ok) chk(conv_chan == 4'(c), "R3 start channel", conv_chan, c);
      @(negedge clk);
      chk(!conv_start, "R11 single-cycle start", conv_start, 0);
      idle(LAT + 6);
      chk(n_start - base == int'(ok), "R8 start count", n_start - base, ok);
      if (ok) chk(log_ch[base % 256] == c, "R3 converted channel", log_ch[base % 256], c);
      chk(reg_rdata == (ok ? (8'h80 | 8'(c)) : 8'(c)), "R3 reg after single",
          reg_rdata, ok ? (8'h80 | c) : c);
      chk(irq == ok, "R4 flag after single", irq, ok);
      ack();
      chk(!irq && reg_rdata == 8'(c), "R5 ack clears flag", reg_rdata, c);
    end

    // R7 re-start while busy
    base = n_start;
    wr(8'h12); idle(2);
    wr(8'h15);
    idle(LAT + 8);
    chk(n_start - base == 1, "R7 one start only", n_start - base, 1);
    chk(log_ch[base % 256] == 2, "R7 channel kept", log_ch[base % 256], 2);
    chk(reg_rdata == 8'h85, "R7 reg after", reg_rdata, 8'h85);
    wr(8'h00);
    chk(!irq && reg_rdata == 8'h00, "R5 software clear", reg_rdata, 0);

    // R6 continuous
    base = n_start;
    wr(8'h27); idle(30);
    wr(8'h00); idle(15);
    n1 = n_start;
    chk(n1 - base >= 3, "R6 repeated starts", n1 - base, 3);
    for (int i = 0; i < n1 - base; i++)
      chk(log_ch[(base + i) % 256] == 7, "R6 channel", log_ch[(base + i) % 256], 7);
    chk(log_t[(base + 1) % 256] - log_t[base % 256] == LAT + 3, "R6 restart spacing",
        log_t[(base + 1) % 256] - log_t[base % 256], LAT + 3);
    idle(20);
    chk(n_start == n1, "R6 stops after clear", n_start - n1, 0);
    ack();

    // R9 full code sweep from memory
    for (int i = 0; i < 15; i++) mem[i] = 4'(i);
    mem[15] = 4'd15;
    base = n_start; rbase = n_rd;
    wr(8'h45);
    wait_irq(400);
    idle(3);
    chk(n_start - base == 13, "R9 sequence starts", n_start - base, 13);
    for (int i = 0; i < 13; i++)
      chk(log_ch[(base + i) % 256] == i, "R9 memory channel", log_ch[(base + i) % 256], i);
    chk(n_rd - rbase == 16, "R9 memory reads", n_rd - rbase, 16);
    chk(reg_rdata == 8'h85, "R9 enable cleared, R4 flag set", reg_rdata, 8'h85);
    ack();

    // R9 empty list restarts at address 0
    mem[0] = 4'd15;
    base = n_start; rbase = n_rd;
    wr(8'h40); idle(12);
    chk(n_start == base, "R9 empty list no start", n_start - base, 0);
    chk(n_rd - rbase == 1, "R9 restart at address 0", n_rd - rbase, 1);
    chk(reg_rdata == 8'h80, "R4 flag on empty list", reg_rdata, 8'h80);
    ack();

    // R10 sequence before continuous
    mem[0] = 4'd4; mem[1] = 4'd11; mem[2] = 4'd15;
    base = n_start;
    wr(8'h61);
    wait_irq(200);
    idle(20);
    wr(8'h00); idle(15);
    chk(n_start - base >= 3, "R10 starts", n_start - base, 3);
    chk(log_ch[base % 256] == 4, "R10 first from memory", log_ch[base % 256], 4);
    chk(log_ch[(base + 1) % 256] == 11, "R10 second from memory", log_ch[(base + 1) % 256], 11);
    for (int i = 2; i < n_start - base; i++)
      chk(log_ch[(base + i) % 256] == 1, "R10 continuous resumes", log_ch[(base + i) % 256], 1);
    ack();

    chk(overlap == 0, "R11 no overlapping start", overlap, 0);
    finish_run();
  end
endmodule